// File: doc/BRIEF.md
# Prescaled PWM Channel with Shadow Commit

This block drives one pulse-width-modulated output from a four-register control bus. A prescaler turns the input clock into counter steps of (P+1) clock cycles each, where P is the prescale setting. A period counter counts steps from zero, and the output is high while the count is below the duty setting D and low for the rest of a period of M steps. All lengths are whole clock cycles. The high time is (P+1)*D cycles and the period is (P+1)*M cycles.

Period and duty settings are double-buffered. A write to the period register only fills a staging copy. A write to the duty register is the commit: it moves the staged period and the new duty together into a committed pair. The running counter loads that pair at the next period boundary, so a period always finishes with the settings it started with. While the channel is stopped, a commit is loaded at once. Software therefore writes prescale, then period, and writes duty last.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the output is low, the channel is stopped, and all four registers read as zero.
- R2: The register select is 0 for prescale, 1 for period (M), 2 for duty (D) and 3 for run control (bit 0). A read (valid high, write low) returns the selected value in the same cycle, zero-extended. When no read is presented, the read data is zero.
- R3: While running with 0 < D < M, each high phase lasts (P+1)*D clock cycles and each low phase lasts (P+1)*(M-D) clock cycles.
- R4: A write to the period register alone changes neither the output waveform nor the period value read back.
- R5: A write to the duty register commits the staged period together with the written duty. From the next cycle, both appear on read-back.
- R6: While running, a commit takes effect at the next period boundary. The period in progress completes with the old settings.
- R7: A commit made while stopped is loaded at once. Writing 1 to run control starts a period from step zero with the high phase first, and that phase is a full (P+1)*D cycles long.
- R8: Writing 0 to run control drives the output low from the next cycle, and it stays low. Run control reads back the current run state.
- R9: With D >= M the output stays high for the whole period. With D = 0 it stays low.
- R10: Duty is masked to CNT_W bits (8 by default) on write and on read-back.
- R11: A prescale write takes effect without a commit and changes the step length of the running waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, same cycle |
| pwm_out | output | 1 | Active-high PWM output |

## Verification
The assertions assume at most one bus access per cycle. They also assume that a period value of zero is never committed while the channel is running. The bench drives a single access per cycle through its write and read tasks, from the falling edge. Every period it commits is non-zero. Phase lengths are measured as counts of falling-edge samples of the output between transitions, so the checks do not depend on how many cycles the pipeline takes to start.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    typedef enum logic [1:0] {
        SEL_PRESCALE = 2'd0,
        SEL_PERIOD   = 2'd1,
        SEL_DUTY     = 2'd2,
        SEL_RUN      = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [1:0]        bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic [PRE_W-1:0]  pre_o,
    output logic [CNT_W-1:0]  cmt_mod_o,
    output logic [CNT_W-1:0]  cmt_duty_o,
    output logic              run_o,
    output logic              commit_o
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] mod_stage;
        logic [CNT_W-1:0] cmt_mod;
        logic [CNT_W-1:0] cmt_duty;
        logic             run;
    } regs_t;

    regs_t    s_d, s_q;
    logic     wr_en, rd_en;
    reg_sel_e sel;

    always_comb begin
        s_d         = s_q;
        sel         = reg_sel_e'(bus_addr_i);
        wr_en       = bus_valid_i && bus_write_i;
        rd_en       = bus_valid_i && !bus_write_i;
        commit_o    = wr_en && (sel == SEL_DUTY);
        bus_rdata_o = '0;
        if (wr_en) begin
            case (sel)
                SEL_PRESCALE: s_d.pre       = bus_wdata_i[PRE_W-1:0];
                SEL_PERIOD:   s_d.mod_stage = bus_wdata_i[CNT_W-1:0];
                SEL_DUTY: begin
                    s_d.cmt_mod  = s_q.mod_stage;
                    s_d.cmt_duty = bus_wdata_i[CNT_W-1:0];
                end
                default:      s_d.run       = bus_wdata_i[0];
            endcase
        end
        if (rd_en) begin
            case (sel)
                SEL_PRESCALE: bus_rdata_o[PRE_W-1:0] = s_q.pre;
                SEL_PERIOD:   bus_rdata_o[CNT_W-1:0] = s_q.cmt_mod;
                SEL_DUTY:     bus_rdata_o[CNT_W-1:0] = s_q.cmt_duty;
                default:      bus_rdata_o[0]         = s_q.run;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pre_o      = s_q.pre;
    assign cmt_mod_o  = s_q.cmt_mod;
    assign cmt_duty_o = s_q.cmt_duty;
    assign run_o      = s_q.run;

    // R4
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_i && bus_write_i && bus_addr_i == 2'd1) |=> $stable(cmt_mod_o));

    // R5
    commit_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (cmt_duty_o == $past(bus_wdata_i[CNT_W-1:0])) && (cmt_mod_o == $past(s_q.mod_stage)));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PRE_W-1:0] pre_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        // ">=" ends a step promptly when prescale is lowered mid-step
        tick_o = run_i && (s_q.cnt >= pre_i);
        if (!run_i || tick_o) s_d.cnt = '0;
        else                  s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R11
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_o) |=> (s_q.cnt == $past(s_q.cnt) + 1'b1) || !run_i);

endmodule

// File: rtl/pwm_period.sv
module pwm_period #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             commit_i,
    input  logic [CNT_W-1:0] cmt_mod_i,
    input  logic [CNT_W-1:0] cmt_duty_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] act_mod;
        logic [CNT_W-1:0] act_duty;
        logic             pend;
    } per_t;

    per_t             s_d, s_q;
    logic [CNT_W-1:0] last;
    logic             boundary, load;

    always_comb begin
        s_d      = s_q;
        // a period of zero steps behaves as one step
        last     = (s_q.act_mod == '0) ? '0 : s_q.act_mod - 1'b1;
        boundary = run_i && tick_i && (s_q.cnt >= last);
        load     = s_q.pend && (!run_i || boundary);
        if (!run_i)         s_d.cnt = '0;
        else if (boundary)  s_d.cnt = '0;
        else if (tick_i)    s_d.cnt = s_q.cnt + 1'b1;
        if (load) begin
            s_d.act_mod  = cmt_mod_i;
            s_d.act_duty = cmt_duty_i;
        end
        if (commit_i)  s_d.pend = 1'b1;
        else if (load) s_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm_o = run_i && (s_q.cnt < s_q.act_duty);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (s_q.cnt <= last));

    // R6
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.pend |=> ($stable(s_q.act_mod) && $stable(s_q.act_duty)));

    // R7
    start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (s_q.cnt == '0));

    // R8
    stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_i) |-> (s_q.cnt == '0 || !pwm_o));

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan #(
    parameter int DATA_W = 32,
    parameter int PRE_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cmt_mod, cmt_duty;
    logic             run, commit, tick;

    pwm_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid), .bus_write_i(bus_write),
        .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .pre_o(pre), .cmt_mod_o(cmt_mod), .cmt_duty_o(cmt_duty),
        .run_o(run), .commit_o(commit)
    );

    pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run_i(run), .pre_i(pre), .tick_o(tick)
    );

    pwm_period #(.CNT_W(CNT_W)) u_per (
        .clk(clk), .rst_n(rst_n), .run_i(run), .tick_i(tick),
        .commit_i(commit), .cmt_mod_i(cmt_mod), .cmt_duty_i(cmt_duty),
        .pwm_o(pwm_out)
    );

    // R8
    stopped_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_addr == 2'd3 && !bus_wdata[0]) |=> !pwm_out);

endmodule

// File: tb/sim_pwm_shadow_chan.sv
module sim_pwm_shadow_chan;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          pwm_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    pwm_shadow_chan u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1;
        chk(bus_rdata == DW'(exp), req, int'(bus_rdata), exp);
        bus_valid = 1'b0;
    endtask

    task automatic meas(output int hi, output int lo);
        while (pwm_out)  @(negedge clk);
        while (!pwm_out) @(negedge clk);
        hi = 0;
        while (pwm_out)  begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm_out) begin lo++; @(negedge clk); end
    endtask

    task automatic level_hold(input bit lvl, input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out !== lvl) bad++;
            @(negedge clk);
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset();
        chk(pwm_out == 1'b0, "R1 output", int'(pwm_out), 0);
        rd_chk(2'd0, 0, "R1 prescale");
        rd_chk(2'd1, 0, "R1 period");
        rd_chk(2'd2, 0, "R1 duty");
        rd_chk(2'd3, 0, "R1 run");
    endtask

    task automatic t_basic();
        int hi, lo;
        wr(2'd0, 1); wr(2'd1, 4); wr(2'd2, 1); wr(2'd3, 1);
        rd_chk(2'd0, 1, "R2 prescale readback");
        rd_chk(2'd3, 1, "R2 run readback");
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 2'd0; bus_wdata = 0;
        bus_valid = 1'b0; #1;
        chk(bus_rdata == '0, "R2 idle rdata", int'(bus_rdata), 0);
        bus_write = 1'b0;
        meas(hi, lo);
        chk(hi == 2, "R3 high", hi, 2);
        chk(lo == 6, "R3 low", lo, 6);
        wr(2'd0, 3);
        meas(hi, lo); meas(hi, lo);
        chk(hi == 4, "R11 high", hi, 4);
        chk(lo == 12, "R11 low", lo, 12);
    endtask

    task automatic t_boundary();
        int hi, lo;
        while (!pwm_out) @(negedge clk);
        while (pwm_out)  @(negedge clk);
        lo = 1;
        wr(2'd2, 3);
        while (!pwm_out) begin lo++; @(negedge clk); end
        hi = 0;
        while (pwm_out)  begin hi++; @(negedge clk); end
        chk(lo == 12, "R6 old period finishes", lo, 12);
        chk(hi == 12, "R6 new duty next period", hi, 12);
    endtask

    task automatic t_shadow();
        int hi, lo;
        wr(2'd0, 1); wr(2'd1, 4); wr(2'd2, 1);
        meas(hi, lo);
        wr(2'd1, 8);
        meas(hi, lo); meas(hi, lo);
        chk(hi == 2 && lo == 6, "R4 waveform unchanged", lo, 6);
        rd_chk(2'd1, 4, "R4 period readback");
        wr(2'd2, 1);
        rd_chk(2'd1, 8, "R5 period committed");
        rd_chk(2'd2, 1, "R5 duty committed");
        meas(hi, lo); meas(hi, lo);
        chk(hi == 2, "R5 high", hi, 2);
        chk(lo == 14, "R5 low", lo, 14);
    endtask

    task automatic t_disable();
        while (!pwm_out) @(negedge clk);
        wr(2'd3, 0);
        chk(pwm_out == 1'b0, "R8 low after stop", int'(pwm_out), 0);
        level_hold(1'b0, 40, "R8 stays low");
        rd_chk(2'd3, 0, "R8 run readback");
    endtask

    task automatic t_restart();
        int hi, lo;
        wr(2'd0, 1); wr(2'd1, 4); wr(2'd2, 2); wr(2'd3, 1);
        chk(pwm_out == 1'b1, "R7 starts high", int'(pwm_out), 1);
        hi = 0;
        while (pwm_out)  begin hi++; @(negedge clk); end
        lo = 0;
        while (!pwm_out) begin lo++; @(negedge clk); end
        chk(hi == 4, "R7 first high full", hi, 4);
        chk(lo == 4, "R7 first low", lo, 4);
    endtask

    task automatic t_extremes();
        wr(2'd0, 0); wr(2'd1, 4); wr(2'd2, 4);
        repeat (20) @(negedge clk);
        level_hold(1'b1, 30, "R9 duty equals period");
        wr(2'd2, 0);
        repeat (20) @(negedge clk);
        level_hold(1'b0, 30, "R9 duty zero");
    endtask

    task automatic t_mask();
        wr(2'd2, 32'h0000_01FF);
        rd_chk(2'd2, 255, "R10 duty masked");
        repeat (20) @(negedge clk);
        level_hold(1'b1, 30, "R10 masked duty above period");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_boundary();
        t_shadow();
        t_disable();
        t_restart();
        t_extremes();
        t_mask();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule